// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address. It fetches exactly one page table entry from memory for each request. A requester presents a virtual address together with a read/write flag. The walker splits the address into a 20-bit virtual page number and a 12-bit page offset. It forms the entry address by scaling the page number by the 4-byte entry size and adding it to a table base register. It then issues a single word read on a valid/ready memory port.

When the entry returns, the walker inspects its presence and permission flags. It answers with a 2-bit status and, on success, the physical address. The physical address is the entry's 18-bit frame number followed by the untouched page offset. Software can rewrite the table base at any time to switch address spaces. A walk already in progress keeps the base value it captured when it was accepted.

The walker serves one request at a time through five named states:

- IDLE: waiting for a request.
- ISSUE_READ: holding the memory read.
- WAIT_DATA: waiting for the entry.
- CHECK: classifying the entry.
- RESPOND: holding the answer.

The transitions are taken on these events:

| From | To | Event |
|------|----|-------|
| IDLE | ISSUE_READ | request accepted |
| ISSUE_READ | WAIT_DATA | memory read accepted |
| WAIT_DATA | CHECK | entry returned |
| CHECK | RESPOND | always, after one cycle |
| RESPOND | IDLE | response acknowledged |

Top module: `pt_walker`

## Requirements
- R1: On a successful translation (status 00), `rsp_paddr[11:0]` equals the request's `req_vaddr[11:0]`, and `rsp_paddr[29:12]` equals bits 17:0 of the returned entry.
- R2: Each accepted request produces exactly one memory read. The read address is `base + req_vaddr[31:12]*4`, taken modulo 2^32.
- R3: A write on `base_wr_en` sets the table base used by every later-accepted request. A base write in the same cycle as a request acceptance does not affect that request. After reset the base is zero.
- R4: A base write while a walk is in progress (after acceptance) does not change that walk's read address.
- R5: If entry bit 31 (present) is clear, the status is 01 (page fault) and `rsp_paddr` is zero, whatever the permission bits hold.
- R6: If the entry is present and either of these holds, the status is 10 (protection fault) and `rsp_paddr` is zero:
  - a read is requested and bit 30 (read allowed) is clear;
  - a write is requested and bit 29 (write allowed) is clear.
- R7: Status 00 means success, and the status value 11 is never produced.
- R8: `req_ready` is high only in IDLE. It drops in the cycle after acceptance and stays low until the response is acknowledged. Only one walk is ever outstanding.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_status` and `rsp_paddr` hold their values.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the read request and its address hold.
- R11: After reset, `req_ready` is high and `mem_req_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid (one-cycle pulse) |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr | output | 30 | Physical address, zero on a fault |

## Verification
The assertions watch the handshake discipline on every cycle. They cover the one-walk-at-a-time rule on `req_ready`, the holding of both the memory request and the response under back-pressure, and the legality of the status code. They also check that every faulting response carries a zero address.

Whether the read address, the fault class and the assembled physical address are right for a given entry depends on data the checker does not see. The bench scenarios show these properties by sweeping page numbers, access types and table bases against an arithmetic entry model. The scenarios are also the only place where base-register timing is observed, both for a write in the acceptance cycle and for a write during a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_READ,
        ST_WAIT_DATA,
        ST_CHECK,
        ST_RESPOND
    } walk_state_e;

    typedef enum logic [1:0] {
        XL_OK         = 2'b00,
        XL_PAGE_FAULT = 2'b01,
        XL_PROT_FAULT = 2'b10
    } xl_status_e;

    typedef struct packed {
        logic present;
        logic can_rd;
        logic can_wr;
    } pte_flags_t;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data;
        end
    end
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ADDR_W    = 32,
    parameter int VPN_W     = 20,
    parameter int PTE_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int SHIFT = $clog2(PTE_BYTES);
    localparam int PAD_W = ADDR_W - VPN_W;

    logic [ADDR_W-1:0] scaled;

    generate
        if (PAD_W > 0) begin : g_pad
            assign scaled = {{PAD_W{1'b0}}, vpn} << SHIFT;
        end else begin : g_nopad
            assign scaled = vpn[ADDR_W-1:0] << SHIFT;
        end
    endgenerate

    assign entry_addr = base + scaled;
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
    import pt_walker_pkg::*;
#(
    parameter int PPN_W = 18,
    parameter int OFF_W = 12,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  pte_flags_t       flags,
    input  logic             is_write,
    input  logic [PPN_W-1:0] ppn,
    input  logic [OFF_W-1:0] offset,
    output logic [1:0]       status,
    output logic [PA_W-1:0]  paddr
);
    logic allowed;

    always_comb begin
        allowed = is_write ? flags.can_wr : flags.can_rd;
        if (!flags.present) begin
            status = XL_PAGE_FAULT;
            paddr  = '0;
        end else if (!allowed) begin
            status = XL_PROT_FAULT;
            paddr  = '0;
        end else begin
            status = XL_OK;
            paddr  = {ppn, offset};
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PPN_W     = 18,
    parameter int ADDR_W    = 32,
    parameter int PTE_W     = 32,
    parameter int PRESENT_B = 31,
    parameter int RD_B      = 30,
    parameter int WR_B      = 29,
    localparam int VPN_W    = VA_W - OFF_W,
    localparam int PA_W     = PPN_W + OFF_W,
    localparam int PTE_BYTES = PTE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status,
    output logic [PA_W-1:0]   rsp_paddr
);
    walk_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] walk_base_q;
    logic [VPN_W-1:0]  walk_vpn_q;
    logic [OFF_W-1:0]  walk_off_q;
    logic              walk_wr_q;
    logic [PTE_W-1:0]  pte_q;
    logic [1:0]        res_status_q;
    logic [PA_W-1:0]   res_paddr_q;

    logic [ADDR_W-1:0] entry_addr;
    logic [1:0]        chk_status;
    logic [PA_W-1:0]   chk_paddr;
    pte_flags_t        pte_flags;
    logic              unused_pte;

    logic accept, mem_fire, rsp_fire;

    pt_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_q  (base_q)
    );

    pt_entry_addr #(
        .ADDR_W    (ADDR_W),
        .VPN_W     (VPN_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_addr (
        .base       (walk_base_q),
        .vpn        (walk_vpn_q),
        .entry_addr (entry_addr)
    );

    assign pte_flags.present = pte_q[PRESENT_B];
    assign pte_flags.can_rd  = pte_q[RD_B];
    assign pte_flags.can_wr  = pte_q[WR_B];
    assign unused_pte        = ^pte_q;

    pt_pte_check #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_check (
        .flags    (pte_flags),
        .is_write (walk_wr_q),
        .ppn      (pte_q[PPN_W-1:0]),
        .offset   (walk_off_q),
        .status   (chk_status),
        .paddr    (chk_paddr)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign mem_fire = mem_req_ready && (state_q == ST_ISSUE_READ);
    assign rsp_fire = rsp_ready && (state_q == ST_RESPOND);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid)     state_d = ST_ISSUE_READ;
            ST_ISSUE_READ: if (mem_req_ready) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA:  if (mem_rsp_valid) state_d = ST_CHECK;
            ST_CHECK:                         state_d = ST_RESPOND;
            ST_RESPOND:    if (rsp_ready)     state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE:       req_ready     = 1'b1;
            ST_ISSUE_READ: mem_req_valid = 1'b1;
            ST_RESPOND:    rsp_valid     = 1'b1;
            default: ;
        endcase
    end

    assign mem_req_addr = entry_addr;
    assign rsp_status   = res_status_q;
    assign rsp_paddr    = res_paddr_q;

    // walk context, captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_base_q <= '0;
            walk_vpn_q  <= '0;
            walk_off_q  <= '0;
            walk_wr_q   <= 1'b0;
        end else if (accept) begin
            walk_base_q <= base_q;
            walk_vpn_q  <= req_vaddr[VA_W-1:OFF_W];
            walk_off_q  <= req_vaddr[OFF_W-1:0];
            walk_wr_q   <= req_write;
        end
    end

    // entry capture and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_q        <= '0;
            res_status_q <= XL_OK;
            res_paddr_q  <= '0;
        end else begin
            if (state_q == ST_WAIT_DATA && mem_rsp_valid) begin
                pte_q <= mem_rsp_data;
            end
            if (state_q == ST_CHECK) begin
                res_status_q <= chk_status;
                res_paddr_q  <= chk_paddr;
            end
        end
    end

    logic unused_fire;
    assign unused_fire = mem_fire ^ rsp_fire;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int PA_W   = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [1:0]        rsp_status,
    input logic [PA_W-1:0]   rsp_paddr
);
    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(mem_req_valid || rsp_valid));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_status) && $stable(rsp_paddr)));

    // R10
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11));

    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'b00) |-> (rsp_paddr == '0));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_status    (rsp_status),
    .rsp_paddr     (rsp_paddr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [29:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cur_base = '0;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_of(input logic [31:0] addr);
        return (addr * 32'h9E37_79B1) ^ (addr >> 5) ^ 32'h5A5A_0000;
    endfunction

    // one walk; mid_base: write base during the memory stall
    task automatic walk(input logic [19:0] vpn, input logic wr, input int stall_a,
                        input int stall_b, input int stall_c,
                        input bit same_cyc_wr, input bit mid_wr, input logic [31:0] new_base);
        logic [31:0] vaddr, exp_addr, pte, exp_pa;
        logic [1:0]  exp_st;
        int          n;
        vaddr    = {vpn, 12'((vpn * 13) ^ 12'hA5C)};
        exp_addr = cur_base + {10'd0, vpn, 2'b00};
        @(negedge clk);
        check(req_ready == 1'b1, "R8 idle ready", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = vaddr; req_write = wr;
        if (same_cyc_wr) begin
            base_wr_en = 1'b1; base_wr_data = new_base;
        end
        @(negedge clk);
        req_valid = 1'b0; base_wr_en = 1'b0;
        if (same_cyc_wr) cur_base = new_base;
        check(req_ready == 1'b0, "R8 busy after accept", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < stall_a; i++) begin
            if (mid_wr && i == 0) begin
                base_wr_en = 1'b1; base_wr_data = new_base;
            end
            check(mem_req_valid && mem_req_addr == exp_addr, "R2 R4 R10 read addr held",
                  mem_req_addr, exp_addr);
            @(negedge clk);
            base_wr_en = 1'b0;
        end
        if (mid_wr) cur_base = new_base;
        check(mem_req_valid && mem_req_addr == exp_addr, "R2 read addr", mem_req_addr, exp_addr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid == 1'b0, "R2 single read", {31'd0, mem_req_valid}, 32'd0);
        repeat (stall_b) @(negedge clk);
        pte = pte_of(exp_addr);
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        n = 0;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        if (!pte[31]) begin
            exp_st = 2'b01; exp_pa = '0;
        end else if (wr ? !pte[29] : !pte[30]) begin
            exp_st = 2'b10; exp_pa = '0;
        end else begin
            exp_st = 2'b00; exp_pa = {2'b00, pte[17:0], vaddr[11:0]};
        end
        check(rsp_valid == 1'b1, "R8 response arrives", {31'd0, rsp_valid}, 32'd1);
        check(rsp_status == exp_st,
              exp_st == 2'b01 ? "R5 page fault" : (exp_st == 2'b10 ? "R6 protection" : "R7 ok status"),
              {30'd0, rsp_status}, {30'd0, exp_st});
        check({2'b00, rsp_paddr} == exp_pa, exp_st == 2'b00 ? "R1 paddr" : "R5 R6 zero paddr",
              {2'b00, rsp_paddr}, exp_pa);
        for (int i = 0; i < stall_c; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_status == exp_st && {2'b00, rsp_paddr} == exp_pa && !req_ready,
                  "R9 response held", {2'b00, rsp_paddr}, exp_pa);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(req_ready && !rsp_valid, "R8 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        cur_base = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready && !mem_req_valid && !rsp_valid, "R11 reset outputs",
              {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'd4);
        // R3 base resets to zero
        walk(20'h00003, 1'b0, 0, 0, 0, 1'b0, 1'b0, 32'd0);

        for (int b = 0; b < 3; b++) begin
            set_base(b == 0 ? 32'h0000_0000 : (b == 1 ? 32'h0010_0400 : 32'hFFFF_F000));
            for (int v = 0; v < 64; v++) begin
                walk(20'(v), 1'b0, v % 3, v % 2, v % 4, 1'b0, 1'b0, 32'd0);
                walk(20'(v), 1'b1, (v + 1) % 3, 0, v % 2, 1'b0, 1'b0, 32'd0);
            end
            // high page numbers, address wraps modulo 2^32 (R2)
            walk(20'hFFFFF, 1'b0, 1, 1, 1, 1'b0, 1'b0, 32'd0);
            walk(20'hFFFFF, 1'b1, 0, 0, 0, 1'b0, 1'b0, 32'd0);
            walk(20'h80001, 1'b1, 2, 0, 1, 1'b0, 1'b0, 32'd0);
        end

        // R3 same-cycle write does not affect accepted request, later ones use it
        set_base(32'h0002_0000);
        walk(20'h00011, 1'b0, 1, 0, 0, 1'b1, 1'b0, 32'h0300_0000);
        walk(20'h00011, 1'b0, 0, 0, 0, 1'b0, 1'b0, 32'd0);
        // R4 write during walk keeps in-flight base
        walk(20'h00022, 1'b1, 3, 1, 1, 1'b0, 1'b1, 32'h0440_0000);
        walk(20'h00022, 1'b1, 0, 0, 0, 1'b0, 1'b0, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule